// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides whether a PC-relative conditional branch is taken and where it goes, for a 32-bit core with byte addresses and 16-bit instruction words. A branch request carries the address of the branch, the short displacement byte from the opcode word, the optional extension word and a 4-bit condition selector. One cycle later the block reports whether the branch is taken, the target, the fall-through address, the instruction length in bytes, and whether the target is odd.

The block also holds the five condition flags: extend, negative, zero, overflow and carry. They can be loaded directly. They can also be updated by a move-style result, which only touches the zero and negative flags. A compare-style update sets them from a destination minus source subtraction without writing any result. A branch is always judged against the flags as they stood before the edge that registers it. A compare issued one cycle ahead of a branch therefore steers that branch.

Top module: `brcu_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid`, `res_taken` and `ccr_out` are all zero.
- R2: `res_valid` is high in the cycle after a cycle with `br_valid` high, and low in the cycle after a cycle with `br_valid` low.
- R3: A nonzero `br_disp8` gives `res_len` = 2. A zero `br_disp8` selects the long form, which uses `br_ext16` as the displacement and gives `res_len` = 4.
- R4: `res_target` equals `br_pc` + 2 + the selected displacement, sign-extended as a two's-complement value. `res_fallthru` equals `br_pc` + `res_len`.
- R5: `res_misaligned` equals bit 0 of the computed target, and that bit is reported unaltered in `res_target`.
- R6: `br_cond` selects the test, using flags packed in `flag_in`/`ccr_out` as bit4=X, bit3=N, bit2=Z, bit1=V, bit0=C.
  - 0 is always taken and 1 is never taken.
  - 2 is HI (!C&!Z) and 3 is LS (C|Z).
  - 4 is CC (!C) and 5 is CS (C).
  - 6 is NE (!Z) and 7 is EQ (Z).
  - 8 is VC (!V) and 9 is VS (V).
  - 10 is PL (!N) and 11 is MI (N).
  - 12 is GE (N==V) and 13 is LT (N!=V).
  - 14 is GT (!Z&(N==V)) and 15 is LE (Z|(N!=V)).
  - The test uses the flags held before the edge. When `flag_load` is high, `flag_in` is written and overrides any update in the same cycle.
- R7: With `upd_kind` = 1 (move), Z becomes (`upd_dst`==0) and N becomes `upd_dst`[31], while X, V and C are kept. Codes 0 and 3 leave all flags unchanged.
- R8: With `upd_kind` = 2 (compare), the flags come from `upd_dst` − `upd_src`. N is the sign of the difference and Z is set on a zero difference. V is the signed overflow and C is the borrow. X is kept.
- R9: After a compare, a GT branch (code 14) is taken exactly when `upd_dst` > `upd_src` as signed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_load | input | 1 | Write `flag_in` into the flags |
| flag_in | input | 5 | Flag values {X,N,Z,V,C} |
| upd_kind | input | 2 | 0 none, 1 move, 2 compare, 3 none |
| upd_dst | input | DATA_W | Move value or compare destination |
| upd_src | input | DATA_W | Compare source |
| br_valid | input | 1 | Branch request present |
| br_pc | input | ADDR_W | Address of the branch instruction |
| br_disp8 | input | 8 | Short displacement field |
| br_ext16 | input | 16 | Extension word displacement |
| br_cond | input | 4 | Condition selector |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Branch taken |
| res_target | output | ADDR_W | Branch target |
| res_fallthru | output | ADDR_W | Next sequential address |
| res_len | output | 3 | Instruction length in bytes |
| res_misaligned | output | 1 | Target address is odd |
| ccr_out | output | 5 | Current flags {X,N,Z,V,C} |

## Verification
A wrong flag register shows on `ccr_out` one cycle after the update that corrupted it. It also reaches `res_taken` on the next branch, since every condition reads only those five bits. A wrong form decision or a wrong sign extension shows on `res_target`, `res_len` and `res_fallthru` in the cycle right after the request. Vectors therefore use negative short and long displacements, the zero short field and a branch to the very next instruction. Compare cases cover borrow, signed overflow and equality, so that the N/V/C paths are told apart.

// File: rtl/brcu_pkg.sv
package brcu_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SHORT_W = 8;
    localparam int LONG_W  = 16;
    localparam int LEN_W   = 3;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_MOVE = 2'd1,
        UPD_CMP  = 2'd2,
        UPD_RSVD = 2'd3
    } upd_e;

    typedef enum logic [3:0] {
        CND_T  = 4'h0, CND_F  = 4'h1, CND_HI = 4'h2, CND_LS = 4'h3,
        CND_CC = 4'h4, CND_CS = 4'h5, CND_NE = 4'h6, CND_EQ = 4'h7,
        CND_VC = 4'h8, CND_VS = 4'h9, CND_PL = 4'hA, CND_MI = 4'hB,
        CND_GE = 4'hC, CND_LT = 4'hD, CND_GT = 4'hE, CND_LE = 4'hF
    } cond_e;

    function automatic logic cond_holds(input cond_e sel, input ccr_t f);
        logic r;
        case (sel)
            CND_T:   r = 1'b1;
            CND_F:   r = 1'b0;
            CND_HI:  r = !f.c && !f.z;
            CND_LS:  r = f.c || f.z;
            CND_CC:  r = !f.c;
            CND_CS:  r = f.c;
            CND_NE:  r = !f.z;
            CND_EQ:  r = f.z;
            CND_VC:  r = !f.v;
            CND_VS:  r = f.v;
            CND_PL:  r = !f.n;
            CND_MI:  r = f.n;
            CND_GE:  r = (f.n == f.v);
            CND_LT:  r = (f.n != f.v);
            CND_GT:  r = !f.z && (f.n == f.v);
            CND_LE:  r = f.z || (f.n != f.v);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brcu_flag_unit.sv
module brcu_flag_unit
    import brcu_pkg::*;
#(
    parameter int DATA_W = brcu_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_load,
    input  ccr_t              flag_in,
    input  upd_e              upd_kind,
    input  logic [DATA_W-1:0] upd_dst,
    input  logic [DATA_W-1:0] upd_src,
    output ccr_t              ccr
);

    logic [DATA_W:0]   sub_full;
    logic [DATA_W-1:0] diff;
    logic              borrow;
    logic              sgn_ovf;
    ccr_t              ccr_nxt;

    assign sub_full = {1'b0, upd_dst} - {1'b0, upd_src};
    assign diff     = sub_full[DATA_W-1:0];
    assign borrow   = sub_full[DATA_W];
    assign sgn_ovf  = (upd_dst[DATA_W-1] != upd_src[DATA_W-1]) &&
                      (diff[DATA_W-1] != upd_dst[DATA_W-1]);

    always_comb begin
        ccr_nxt = ccr;
        if (flag_load) begin
            ccr_nxt = flag_in;
        end else begin
            case (upd_kind)
                UPD_MOVE: begin
                    ccr_nxt.n = upd_dst[DATA_W-1];
                    ccr_nxt.z = (upd_dst == '0);
                end
                UPD_CMP: begin
                    ccr_nxt.n = diff[DATA_W-1];
                    ccr_nxt.z = (diff == '0);
                    ccr_nxt.v = sgn_ovf;
                    ccr_nxt.c = borrow;
                end
                default: ccr_nxt = ccr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ccr <= '0;
        else     ccr <= ccr_nxt;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        flag_load |=> ccr == $past(flag_in)); // R6
    AST_MOVE_KEEPS_XVC: assert property (@(posedge clk) disable iff (rst)
        (!flag_load && upd_kind == UPD_MOVE) |=>
        (ccr.x == $past(ccr.x) && ccr.v == $past(ccr.v) && ccr.c == $past(ccr.c))); // R7
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!flag_load && (upd_kind == UPD_NONE || upd_kind == UPD_RSVD)) |=> $stable(ccr)); // R7
    AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (rst)
        (!flag_load && upd_kind == UPD_CMP) |=> ccr.x == $past(ccr.x)); // R8
    AST_CMP_EQUAL_Z: assert property (@(posedge clk) disable iff (rst)
        (!flag_load && upd_kind == UPD_CMP && upd_dst == upd_src) |=> (ccr.z && !ccr.c)); // R8

endmodule

// File: rtl/brcu_cond_eval.sv
module brcu_cond_eval
    import brcu_pkg::*;
(
    input  cond_e sel,
    input  ccr_t  flags,
    output logic  taken
);

    assign taken = cond_holds(sel, flags);

endmodule

// File: rtl/brcu_target_gen.sv
module brcu_target_gen #(
    parameter int ADDR_W  = brcu_pkg::ADDR_W,
    parameter int SHORT_W = brcu_pkg::SHORT_W,
    parameter int LONG_W  = brcu_pkg::LONG_W,
    parameter int LEN_W   = brcu_pkg::LEN_W
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [SHORT_W-1:0] disp_s,
    input  logic [LONG_W-1:0]  disp_l,
    output logic [ADDR_W-1:0]  target,
    output logic [ADDR_W-1:0]  fallthru,
    output logic [LEN_W-1:0]   len,
    output logic               misaligned
);

    localparam int WORD_BYTES = 2;
    localparam int LONG_BYTES = WORD_BYTES + LONG_W / 8;

    logic              long_form;
    logic [ADDR_W-1:0] disp_s_ext;
    logic [ADDR_W-1:0] disp_l_ext;
    logic [ADDR_W-1:0] disp_sel;

    assign long_form  = (disp_s == '0);
    assign disp_s_ext = {{(ADDR_W-SHORT_W){disp_s[SHORT_W-1]}}, disp_s};
    assign disp_l_ext = {{(ADDR_W-LONG_W){disp_l[LONG_W-1]}}, disp_l};
    assign disp_sel   = long_form ? disp_l_ext : disp_s_ext;

    assign target     = pc + ADDR_W'(WORD_BYTES) + disp_sel;
    assign len        = long_form ? LEN_W'(LONG_BYTES) : LEN_W'(WORD_BYTES);
    assign fallthru   = pc + ADDR_W'(len);
    assign misaligned = target[0];

endmodule

// File: rtl/brcu_top.sv
module brcu_top
    import brcu_pkg::*;
#(
    parameter int ADDR_W  = brcu_pkg::ADDR_W,
    parameter int DATA_W  = brcu_pkg::DATA_W,
    parameter int SHORT_W = brcu_pkg::SHORT_W,
    parameter int LONG_W  = brcu_pkg::LONG_W,
    parameter int LEN_W   = brcu_pkg::LEN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flag_load,
    input  logic [4:0]         flag_in,
    input  logic [1:0]         upd_kind,
    input  logic [DATA_W-1:0]  upd_dst,
    input  logic [DATA_W-1:0]  upd_src,
    input  logic               br_valid,
    input  logic [ADDR_W-1:0]  br_pc,
    input  logic [SHORT_W-1:0] br_disp8,
    input  logic [LONG_W-1:0]  br_ext16,
    input  logic [3:0]         br_cond,
    output logic               res_valid,
    output logic               res_taken,
    output logic [ADDR_W-1:0]  res_target,
    output logic [ADDR_W-1:0]  res_fallthru,
    output logic [LEN_W-1:0]   res_len,
    output logic               res_misaligned,
    output logic [4:0]         ccr_out
);

    ccr_t              ccr_q;
    logic              cmb_taken;
    logic [ADDR_W-1:0] cmb_target;
    logic [ADDR_W-1:0] cmb_fallthru;
    logic [LEN_W-1:0]  cmb_len;
    logic              cmb_misaligned;

    brcu_flag_unit #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .flag_load (flag_load),
        .flag_in   (ccr_t'(flag_in)),
        .upd_kind  (upd_e'(upd_kind)),
        .upd_dst   (upd_dst),
        .upd_src   (upd_src),
        .ccr       (ccr_q)
    );

    brcu_cond_eval u_cond (
        .sel   (cond_e'(br_cond)),
        .flags (ccr_q),
        .taken (cmb_taken)
    );

    brcu_target_gen #(
        .ADDR_W (ADDR_W),
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W),
        .LEN_W  (LEN_W)
    ) u_tgt (
        .pc         (br_pc),
        .disp_s     (br_disp8),
        .disp_l     (br_ext16),
        .target     (cmb_target),
        .fallthru   (cmb_fallthru),
        .len        (cmb_len),
        .misaligned (cmb_misaligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid      <= 1'b0;
            res_taken      <= 1'b0;
            res_target     <= '0;
            res_fallthru   <= '0;
            res_len        <= '0;
            res_misaligned <= 1'b0;
        end else begin
            res_valid <= br_valid;
            if (br_valid) begin
                res_taken      <= cmb_taken;
                res_target     <= cmb_target;
                res_fallthru   <= cmb_fallthru;
                res_len        <= cmb_len;
                res_misaligned <= cmb_misaligned;
            end
        end
    end

    assign ccr_out = ccr_q;

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !br_valid |=> !res_valid); // R2
    AST_SHORT_LEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_disp8 != '0) |=> res_len == LEN_W'(2)); // R3
    AST_LONG_LEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_disp8 == '0) |=> res_len == LEN_W'(4)); // R3
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_cond == 4'h0) |=> res_taken); // R6
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_cond == 4'h1) |=> !res_taken); // R6
    AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_cond == 4'h7) |=> res_taken == $past(ccr_out[2])); // R6

endmodule

// File: tb/tb_brcu_top.sv
module tb_brcu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flag_load = 1'b0;
    logic [4:0]  flag_in = '0;
    logic [1:0]  upd_kind = '0;
    logic [31:0] upd_dst = '0;
    logic [31:0] upd_src = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_pc = '0;
    logic [7:0]  br_disp8 = '0;
    logic [15:0] br_ext16 = '0;
    logic [3:0]  br_cond = '0;
    logic        res_valid, res_taken, res_misaligned;
    logic [31:0] res_target, res_fallthru;
    logic [2:0]  res_len;
    logic [4:0]  ccr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    always #2 clk = ~clk;

    brcu_top dut (
        .clk(clk), .rst(rst), .flag_load(flag_load), .flag_in(flag_in),
        .upd_kind(upd_kind), .upd_dst(upd_dst), .upd_src(upd_src),
        .br_valid(br_valid), .br_pc(br_pc), .br_disp8(br_disp8),
        .br_ext16(br_ext16), .br_cond(br_cond), .res_valid(res_valid),
        .res_taken(res_taken), .res_target(res_target),
        .res_fallthru(res_fallthru), .res_len(res_len),
        .res_misaligned(res_misaligned), .ccr_out(ccr_out)
    );

    typedef struct packed {
        logic [4:0]  fl;
        logic [3:0]  cond;
        logic [31:0] pc;
        logic [7:0]  d8;
        logic [15:0] e16;
        logic        tk;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{5'b00000, 4'h0, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b11111, 4'h1, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00000, 4'h2, 32'h0000_2000, 8'hFE, 16'h0, 1'b1, 32'h0000_2000},
        '{5'b00001, 4'h2, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00100, 4'h3, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00000, 4'h3, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00001, 4'h4, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00001, 4'h5, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00100, 4'h6, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00000, 4'h6, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00100, 4'h7, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00000, 4'h7, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00010, 4'h8, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00010, 4'h9, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b01000, 4'hA, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b01000, 4'hB, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b01010, 4'hC, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b01000, 4'hC, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b01000, 4'hD, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00000, 4'hE, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00100, 4'hE, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b01010, 4'hE, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00010, 4'hF, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00000, 4'hF, 32'h0000_1000, 8'h10, 16'h0, 1'b0, 32'h0000_1012},
        '{5'b00100, 4'hF, 32'h0000_1000, 8'h10, 16'h0, 1'b1, 32'h0000_1012},
        '{5'b00000, 4'h0, 32'h0000_3000, 8'h00, 16'h0002, 1'b1, 32'h0000_3004},
        '{5'b00000, 4'h0, 32'h0001_0000, 8'h00, 16'h8000, 1'b1, 32'h0000_8002},
        '{5'b10000, 4'h0, 32'h0000_0100, 8'h81, 16'h0, 1'b1, 32'h0000_0083}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_flags(input logic [4:0] f);
        flag_load = 1'b1;
        flag_in   = f;
        @(negedge clk);
        flag_load = 1'b0;
    endtask

    task automatic do_upd(input logic [1:0] k, input logic [31:0] d, input logic [31:0] s);
        upd_kind = k;
        upd_dst  = d;
        upd_src  = s;
        @(negedge clk);
        upd_kind = 2'd0;
    endtask

    task automatic do_branch(input logic [3:0] c, input logic [31:0] pc,
                             input logic [7:0] d8, input logic [15:0] e16);
        br_valid = 1'b1;
        br_cond  = c;
        br_pc    = pc;
        br_disp8 = d8;
        br_ext16 = e16;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'b0, res_valid}, 32'd0);
        chk("R1 flags in reset", {27'b0, ccr_out}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'b0, res_valid}, 32'd0);
        chk("R1 taken after reset", {31'b0, res_taken}, 32'd0);
        chk("R1 flags after reset", {27'b0, ccr_out}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] elen;
            elen = (VECS[i].d8 == 8'h00) ? 3'd4 : 3'd2;
            load_flags(VECS[i].fl);
            do_branch(VECS[i].cond, VECS[i].pc, VECS[i].d8, VECS[i].e16);
            chk("R2 valid", {31'b0, res_valid}, 32'd1);
            chk("R6 taken", {31'b0, res_taken}, {31'b0, VECS[i].tk});
            chk("R4 target", res_target, VECS[i].tgt);
            chk("R3 length", {29'b0, res_len}, {29'b0, elen});
            chk("R4 fallthru", res_fallthru, VECS[i].pc + {29'b0, elen});
            chk("R5 misaligned", {31'b0, res_misaligned}, {31'b0, VECS[i].tgt[0]});
        end

        @(negedge clk);
        chk("R2 idle no result", {31'b0, res_valid}, 32'd0);

        // R7 move class
        load_flags(5'b10011);
        do_upd(2'd1, 32'h8000_0000, 32'h1234_5678);
        chk("R7 move negative", {27'b0, ccr_out}, {27'b0, 5'b11011});
        do_upd(2'd1, 32'h0000_0000, 32'hFFFF_FFFF);
        chk("R7 move zero", {27'b0, ccr_out}, {27'b0, 5'b10111});
        do_upd(2'd3, 32'h8000_0000, 32'h0);
        chk("R7 reserved ignored", {27'b0, ccr_out}, {27'b0, 5'b10111});

        // R8 / R9 compare class
        load_flags(5'b10000);
        do_upd(2'd2, 32'd5, 32'd3);
        chk("R8 cmp greater", {27'b0, ccr_out}, {27'b0, 5'b10000});
        do_branch(4'hE, 32'h0000_4000, 8'h04, 16'h0);
        chk("R9 gt after 5 vs 3", {31'b0, res_taken}, 32'd1);
        do_upd(2'd2, 32'd3, 32'd5);
        chk("R8 cmp borrow", {27'b0, ccr_out}, {27'b0, 5'b11001});
        do_branch(4'hE, 32'h0000_4000, 8'h04, 16'h0);
        chk("R9 gt after 3 vs 5", {31'b0, res_taken}, 32'd0);
        load_flags(5'b00000);
        do_upd(2'd2, 32'h8000_0000, 32'd1);
        chk("R8 cmp overflow", {27'b0, ccr_out}, {27'b0, 5'b00010});
        do_branch(4'hE, 32'h0000_4000, 8'h04, 16'h0);
        chk("R9 gt after min vs 1", {31'b0, res_taken}, 32'd0);
        do_branch(4'hD, 32'h0000_4000, 8'h04, 16'h0);
        chk("R6 lt after min vs 1", {31'b0, res_taken}, 32'd1);
        do_upd(2'd2, 32'd7, 32'd7);
        chk("R8 cmp equal", {27'b0, ccr_out}, {27'b0, 5'b00100});

        // R6 load overrides a same-cycle update
        flag_load = 1'b1;
        flag_in   = 5'b01010;
        upd_kind  = 2'd1;
        upd_dst   = 32'h0;
        @(negedge clk);
        flag_load = 1'b0;
        upd_kind  = 2'd0;
        chk("R6 load wins", {27'b0, ccr_out}, {27'b0, 5'b01010});

        // R6 branch sees flags from before a same-cycle compare
        upd_kind = 2'd2;
        upd_dst  = 32'd9;
        upd_src  = 32'd9;
        do_branch(4'h7, 32'h0000_5000, 8'h02, 16'h0);
        upd_kind = 2'd0;
        chk("R6 eq uses old flags", {31'b0, res_taken}, 32'd0);

        finish_run();
    end

endmodule